// File: doc/BRIEF.md
# Signed Double-Word Result Multiplier

This block multiplies two 36-bit two's-complement words over several cycles. It has two result modes. In double mode it returns a 71-bit signed product spread over a high word and a low word. In single mode it returns only the low product word, truncated to 36 bits. A one-cycle start strobe captures both operands and the mode. Some cycles later a one-cycle done pulse marks the result, which is presented on the two result words together with an overflow flag and a trap flag.

Inside, the block takes the magnitude of each operand and forms their product with one shift-and-add step per multiplier bit. If the operand signs differ, it negates the product at the end. The low result word does not continue the product into its top bit. Bit 35 of the low word holds a copy of the result sign, and the 71 product bits are spread as 36 bits in the high word plus 35 bits in bits 34..0 of the low word. The most negative operand, -2^35, squared is a special case in both modes, and it raises the flags.

Top module: `sdw_multiplier`

## Requirements
- R1: While reset is high, and until the first result after it, res_hi, res_lo, ovf, trap and done are all 0.
- R2: When start is sampled high with the block idle, done is high for exactly one cycle. That cycle is the 37th rising edge after the edge that took start, and the result words and flags are valid in the same cycle.
- R3: A start that arrives before the result of the current multiply is ready has no effect on the result or on when it appears, and it produces no extra done. The outputs keep their values from one done until the next.
- R4: If either operand is zero, res_hi and res_lo are both zero and ovf is low, in either mode.
- R5: With single_mode=0 and no special case, the exact product P, taken as a 71-bit two's-complement value, is split as follows: res_hi = P[70:35], res_lo[34:0] = P[34:0], and res_lo[35] = P[70].
- R6: With single_mode=0 and operand signs that differ, the result is the 71-bit negation of the magnitude product. res_lo[35] equals res_hi[35], and ovf is low.
- R7: With single_mode=0 and both operands equal to -2^35 (0x800000000), res_hi = 0x800000000, res_lo = 0x800000000, and ovf is high.
- R8: With single_mode=1, res_hi is 0. If P[70:35] is all zeros or all ones, then res_lo = {P[70], P[34:0]} and ovf is low.
- R9: With single_mode=1, if P[70:35] is neither all zeros nor all ones, then ovf is high and res_lo = {sign(a) XOR sign(b), P[34:0]}.
- R10: With single_mode=1 and both operands equal to -2^35, res_lo = 0x800000000, res_hi = 0, and ovf is high.
- R11: trap always carries the same value as ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Strobe that captures the operands and the mode when the block is idle |
| single_mode | input | 1 | 1 selects the truncated single-word result, 0 selects the double-word result |
| op_a | input | 36 | Multiplicand, two's complement |
| op_b | input | 36 | Multiplier, two's complement |
| res_hi | output | 36 | High result word (0 in single mode) |
| res_lo | output | 36 | Low result word; bit 35 carries the result sign |
| done | output | 1 | One-cycle pulse that marks a new result |
| ovf | output | 1 | Arithmetic overflow for the latest result |
| trap | output | 1 | Trap request for the latest result, equal to ovf |

## Verification
Each accepted start gives exactly one result, due 37 rising edges later. The result words and both flags change only in that done cycle. The scoreboard driver stamps each expected item with its due cycle, computed as the cycle of the driving edge plus 38. The monitor samples on falling edges and compares the cycle count as well as the data, so an early or late done counts as a failure. Any done that arrives with an empty queue is also a failure, which covers a start issued mid-multiply. A few cycles after a result, the outputs are sampled again to confirm that they held.

// File: rtl/sdw_mul_pkg.sv
package sdw_mul_pkg;

    localparam int DEF_WORD_W = 36;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mul_state_e;

    // Per-operation context captured with the operands.
    typedef struct packed {
        logic neg;       // operand signs differ
        logic single;    // truncated single-word result requested
        logic both_min;  // both operands are the most negative value
    } op_ctx_t;

    // Two's-complement magnitude of a signed word (most negative maps to 2^(n-1)).
    function automatic logic [DEF_WORD_W-1:0] word_mag(input logic [DEF_WORD_W-1:0] v);
        return v[DEF_WORD_W-1] ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/sdw_operand_prep.sv
module sdw_operand_prep
    import sdw_mul_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic              single_in,
    output logic [WORD_W-1:0] a_mag,
    output logic [WORD_W-1:0] b_mag,
    output op_ctx_t           ctx
);
    localparam logic [WORD_W-1:0] MOST_NEG = {1'b1, {(WORD_W-1){1'b0}}};

    always_comb begin
        a_mag        = a_in[WORD_W-1] ? (~a_in + 1'b1) : a_in;
        b_mag        = b_in[WORD_W-1] ? (~b_in + 1'b1) : b_in;
        ctx.neg      = a_in[WORD_W-1] ^ b_in[WORD_W-1];
        ctx.single   = single_in;
        ctx.both_min = (a_in == MOST_NEG) && (b_in == MOST_NEG);
    end
endmodule

// File: rtl/sdw_shift_add_core.sv
module sdw_shift_add_core #(
    parameter int WORD_W = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  step,
    input  logic [WORD_W-1:0]     mcand,
    input  logic [WORD_W-1:0]     mplier,
    output logic [2*WORD_W-1:0]   prod,
    output logic                  last
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W:0]   upper_q;   // partial sum, one spare carry bit
    logic [WORD_W-1:0] lowq_q;    // multiplier bits, replaced by product bits
    logic [WORD_W-1:0] mcand_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W:0]   sum;

    always_comb begin
        sum = upper_q + (lowq_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            lowq_q  <= '0;
            mcand_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            upper_q <= '0;
            lowq_q  <= mplier;
            mcand_q <= mcand;
            cnt_q   <= '0;
        end else if (step) begin
            upper_q <= {1'b0, sum[WORD_W:1]};
            lowq_q  <= {sum[0], lowq_q[WORD_W-1:1]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign prod = {upper_q[WORD_W-1:0], lowq_q};
    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/sdw_result_fixup.sv
module sdw_result_fixup
    import sdw_mul_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic [2*WORD_W-1:0] prod,
    input  op_ctx_t             ctx,
    output logic [WORD_W-1:0]   hi_out,
    output logic [WORD_W-1:0]   lo_out,
    output logic                flag_out
);
    localparam int LOW_W = WORD_W - 1;
    localparam int SIG_W = 2 * WORD_W - 1;
    localparam logic [WORD_W-1:0] MOST_NEG = {1'b1, {(WORD_W-1){1'b0}}};

    logic [SIG_W-1:0]  mag_sig;
    logic [SIG_W-1:0]  signed_sig;
    logic [WORD_W-1:0] dbl_hi;
    logic [WORD_W-1:0] dbl_lo;
    logic              dbl_flag;
    logic              hi_not_ext;

    always_comb begin
        mag_sig    = prod[SIG_W-1:0];
        signed_sig = ctx.neg ? (~mag_sig + 1'b1) : mag_sig;
        dbl_hi     = signed_sig[SIG_W-1:LOW_W];
        dbl_lo     = {signed_sig[SIG_W-1], signed_sig[LOW_W-1:0]};
        dbl_flag   = !ctx.neg && dbl_hi[WORD_W-1];
        hi_not_ext = (dbl_hi != '0) && (dbl_hi != '1);

        if (!ctx.single) begin
            hi_out   = dbl_hi;
            lo_out   = dbl_lo;
            flag_out = dbl_flag;
        end else if (ctx.both_min) begin
            hi_out   = '0;
            lo_out   = MOST_NEG;
            flag_out = 1'b1;
        end else if (hi_not_ext) begin
            hi_out   = '0;
            lo_out   = {ctx.neg, dbl_lo[LOW_W-1:0]};
            flag_out = 1'b1;
        end else begin
            hi_out   = '0;
            lo_out   = dbl_lo;
            flag_out = 1'b0;
        end
    end
endmodule

// File: rtl/sdw_multiplier.sv
module sdw_multiplier
    import sdw_mul_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              single_mode,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              done,
    output logic              ovf,
    output logic              trap
);
    mul_state_e        state_q;
    op_ctx_t           ctx_now;
    op_ctx_t           ctx_q;
    logic [WORD_W-1:0] a_mag;
    logic [WORD_W-1:0] b_mag;
    logic [2*WORD_W-1:0] prod;
    logic              last;
    logic              accept;
    logic [WORD_W-1:0] fix_hi;
    logic [WORD_W-1:0] fix_lo;
    logic              fix_flag;

    assign accept = start && (state_q == ST_IDLE);

    sdw_operand_prep #(.WORD_W(WORD_W)) prep_i (
        .a_in      (op_a),
        .b_in      (op_b),
        .single_in (single_mode),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .ctx       (ctx_now)
    );

    sdw_shift_add_core #(.WORD_W(WORD_W)) core_i (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (state_q == ST_RUN),
        .mcand  (a_mag),
        .mplier (b_mag),
        .prod   (prod),
        .last   (last)
    );

    sdw_result_fixup #(.WORD_W(WORD_W)) fix_i (
        .prod     (prod),
        .ctx      (ctx_q),
        .hi_out   (fix_hi),
        .lo_out   (fix_lo),
        .flag_out (fix_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            res_hi  <= '0;
            res_lo  <= '0;
            ovf     <= 1'b0;
            trap    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    ctx_q   <= ctx_now;
                    state_q <= ST_RUN;
                end
                ST_RUN: if (last) state_q <= ST_FIX;
                ST_FIX: begin
                    res_hi  <= fix_hi;
                    res_lo  <= fix_lo;
                    ovf     <= fix_flag;
                    trap    <= fix_flag;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdw_multiplier_chk.sv
module sdw_multiplier_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              single_mode,
    input logic [WORD_W-1:0] res_hi,
    input logic [WORD_W-1:0] res_lo,
    input logic              done,
    input logic              ovf,
    input logic              trap
);
    localparam int LAT   = WORD_W + 1;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (cnt_q == '0) begin
            if (start) begin
                cnt_q  <= CNT_W'(LAT);
                mode_q <= single_mode;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2: result is due exactly when the window runs out
    p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == 1) |=> done);

    // R3: no done at any other time, including after an ignored start
    p_no_stray_done_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != 1) |=> !done);

    // R3: outputs move only in the done cycle
    p_hold_outputs_r3: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({res_hi, res_lo, ovf, trap}));

    // R8: single mode leaves the high word at zero
    p_single_hi_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q) |-> (res_hi == '0));

    // R6: double mode copies the result sign into the low word
    p_sign_copy_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (res_lo[WORD_W-1] == res_hi[WORD_W-1]));
endmodule

bind sdw_multiplier sdw_multiplier_chk #(.WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .single_mode (single_mode),
    .res_hi      (res_hi),
    .res_lo      (res_lo),
    .done        (done),
    .ovf         (ovf),
    .trap        (trap)
);

// File: tb/sdw_multiplier_tb_top.sv
`timescale 1ns/1ps
module sdw_multiplier_tb_top;
    localparam int W   = 36;
    localparam int LAT = W + 1;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    typedef struct {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         flag;
        int           due;
        string        tag;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         single_mode = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] res_hi, res_lo;
    logic         done, ovf, trap;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;
    exp_item_t sb[$];
    exp_item_t last_item;

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sdw_multiplier dut_i (
        .clk(clk), .rst(rst), .start(start), .single_mode(single_mode),
        .op_a(op_a), .op_b(op_b), .res_hi(res_hi), .res_lo(res_lo),
        .done(done), .ovf(ovf), .trap(trap)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic sm, output logic [W-1:0] eh,
                                  output logic [W-1:0] el, output logic ef);
        logic signed [2*W-1:0] p;
        logic [W-1:0] dh;
        p  = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        dh = p[2*W-2:W-1];
        if (a == MINV && b == MINV) begin
            eh = sm ? '0 : MINV; el = MINV; ef = 1'b1;
        end else if (!sm) begin
            eh = dh; el = {p[2*W-2], p[W-2:0]}; ef = 1'b0;
        end else begin
            eh = '0;
            if (dh != '0 && dh != '1) begin
                el = {a[W-1] ^ b[W-1], p[W-2:0]}; ef = 1'b1;
            end else begin
                el = {p[2*W-2], p[W-2:0]}; ef = 1'b0;
            end
        end
    endfunction

    // Driver: pushes the expected item, then pulses start.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sm, input string tag);
        exp_item_t it;
        @(negedge clk);
        model(a, b, sm, it.hi, it.lo, it.flag);
        it.due = cyc + LAT + 1;
        it.tag = tag;
        sb.push_back(it);
        op_a = a; op_b = b; single_mode = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_result();
        repeat (LAT + 2) @(negedge clk);
    endtask

    // Monitor: pops and compares whenever a result shows up.
    always @(negedge clk) begin
        if (!rst && done && !finished) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected done", {W{1'b0}}, {W{1'b0}});
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                last_item = it;
                check(cyc == it.due, {it.tag, " R2 latency"}, W'(cyc), W'(it.due));
                check(res_hi == it.hi, {it.tag, " hi"}, res_hi, it.hi);
                check(res_lo == it.lo, {it.tag, " lo"}, res_lo, it.lo);
                check(ovf == it.flag, {it.tag, " ovf"}, W'(ovf), W'(it.flag));
                check(trap == ovf, "R11 trap equals ovf", W'(trap), W'(ovf));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(res_hi == '0 && res_lo == '0, "R1 reset words", res_lo, '0);
        check(!done && !ovf && !trap, "R1 reset flags", {done, ovf, trap}, '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!done && res_lo == '0, "R1 after reset", res_lo, '0);

        issue(36'd3, 36'd5, 1'b0, "R5 small");                      wait_result();
        issue(36'h7FFFFFFFF, 36'h7FFFFFFFF, 1'b0, "R5 max positive"); wait_result();
        issue(-36'sd3, 36'd5, 1'b0, "R6 small negative");          wait_result();
        issue(36'h7FFFFFFFF, -36'sd12345, 1'b0, "R6 large negative"); wait_result();
        issue(MINV, 36'd1, 1'b0, "R6 min times one");               wait_result();
        issue(36'd0, -36'sd7, 1'b0, "R4 zero double");              wait_result();
        issue(MINV, 36'd0, 1'b1, "R4 zero single");                 wait_result();
        issue(MINV, MINV, 1'b0, "R7 min squared double");           wait_result();
        issue(-36'sd3, 36'd5, 1'b1, "R8 single fits");              wait_result();
        issue(MINV, 36'd1, 1'b1, "R8 single min times one");        wait_result();
        issue(36'h100001, 36'h100000, 1'b1, "R9 single overflow pos"); wait_result();
        issue(-36'sd1048579, 36'h100000, 1'b1, "R9 single overflow neg"); wait_result();
        issue(MINV, MINV, 1'b1, "R10 min squared single");          wait_result();

        // R3: a start in mid-operation must be ignored
        issue(36'd1000, -36'sd77, 1'b0, "R3 busy start ignored");
        repeat (10) @(negedge clk);
        op_a = 36'd9; op_b = 36'd9; single_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_result();
        repeat (5) @(negedge clk);
        check(res_hi == last_item.hi && res_lo == last_item.lo,
              "R3 outputs held", res_lo, last_item.lo);
        check(sb.size() == 0, "R3 queue drained", W'(sb.size()), '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule